// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is the integer register file of a processor core that gives each procedure its own sliding window of registers. A window has three groups of eight: outputs, locals and inputs. Eight global registers sit beside the windows and are seen by every procedure. The output group of one window is the same storage as the input group of the next window. When a caller places arguments in its outputs and then saves, the callee finds them in its inputs, and nothing is copied.

A save moves the current window pointer forward and a restore moves it back, modulo the number of windows. A counter tracks how many caller windows are still held on chip. A save that would run out of free windows raises an overflow trap. A restore whose caller window has already left the chip raises an underflow trap. In both cases the pointer stays where it was.

The block has two combinational read ports and one clocked write port. A call-link input stores the return address, and a return-address output reads it back in the callee. A trap handler uses a side port to read or write any physical windowed register by window index and offset. Its spill-done and fill-done strobes adjust the resident count so that the trapped save or restore can be retried.

Top module: `winreg_file`

## Requirements
- R1: Logical register numbers are decoded as follows: 0-7 are globals shared by every window, 8-15 are the outputs, 16-23 the locals and 24-31 the inputs of the current window. A value written through the write port reads back from the same number on both read ports once the clock edge has passed.
- R2: Output j (number 8+j) of window w is the same storage as input j (number 24+j) of window (w+1) mod NWIN, and this holds across the wrap from window NWIN-1 to window 0.
- R3: An accepted save sets cur_win to (cur_win+1) mod NWIN and raises resident by one at the next edge. An accepted restore sets cur_win to (cur_win-1) mod NWIN and lowers resident by one. A restore is ignored while save_req is high.
- R4: A local written in one window leaves the locals of every other window unchanged.
- R5: A save while resident equals NWIN-2 drives ovf_trap high in the same cycle, combinationally. cur_win and resident then stay unchanged.
- R6: A restore (with save_req low) while resident is 0 drives unf_trap high in the same cycle. cur_win and resident then stay unchanged.
- R7: link_en writes link_pc into output 7 (number 15) of the current window at the edge. ret_addr always shows input 7 (number 31) of the current window.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: A read port addressing the register being written in the same cycle returns the new value. A write, or a link, issued in the same cycle as a save lands in the window that was current before the save.
- R10: The handler port addresses physical register 8 + 16*hs_win + hs_off. Offsets 0-7 are the outputs and 8-15 the locals of that window. hs_we writes at the edge. hs_rdata shows the stored value combinationally.
- R11: With neither save_req nor restore_req high, spill_done alone lowers resident by one and fill_done alone raises it by one. spill_done at 0, fill_done at NWIN-2, and both strobes together are ignored.
- R12: After reset, cur_win and resident are 0, both traps are low, and every register reads zero.
- R13: When several writes target one physical register in the same cycle, the link write wins over the port write, which wins over the handler write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs1_addr | input | 5 | Read port A logical number |
| rs1_data | output | XLEN | Read port A data |
| rs2_addr | input | 5 | Read port B logical number |
| rs2_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 5 | Write port logical number |
| wr_data | input | XLEN | Write port data |
| link_en | input | 1 | Store return address in output 7 |
| link_pc | input | XLEN | Return address to store |
| ret_addr | output | XLEN | Input 7 of the current window |
| save_req | input | 1 | Advance the window |
| restore_req | input | 1 | Step the window back |
| ovf_trap | output | 1 | Save refused, no free window |
| unf_trap | output | 1 | Restore refused, caller not resident |
| cur_win | output | WW | Current window pointer |
| resident | output | WW | Caller windows held on chip |
| hs_win | input | WW | Handler port window index |
| hs_off | input | 4 | Handler port offset in window |
| hs_we | input | 1 | Handler port write enable |
| hs_wdata | input | XLEN | Handler port write data |
| hs_rdata | output | XLEN | Handler port read data |
| spill_done | input | 1 | Handler moved oldest window out |
| fill_done | input | 1 | Handler brought a caller window back |

## Verification
A save can fall in the same cycle as a register write and a call link. The window moves at the same edge at which those writes land. The bench provokes this with one cycle that drives save_req, link_en and a write to an output register together. Afterwards it reads the callee's matching input and ret_addr. The values must show that both writes used the pre-save window. A second collision drives the link and the write port at output 7 together, and the link value must be the one that survives.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    localparam int GRP_SZ  = 8;
    localparam int LADDR_W = 5;

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } grp_e;
endpackage

// File: rtl/winreg_xlat.sv
module winreg_xlat
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN),
    parameter int PAW  = $clog2(8 + 16 * NWIN)
) (
    input  logic [WW-1:0]      win,
    input  logic [LADDR_W-1:0] laddr,
    output logic [PAW-1:0]     paddr
);
    localparam logic [WW-1:0] LASTW = WW'(NWIN - 1);

    grp_e          grp;
    logic [2:0]    idx;
    logic [WW-1:0] prev_win;

    always_comb begin
        grp      = grp_e'(laddr[4:3]);
        idx      = laddr[2:0];
        prev_win = (win == '0) ? LASTW : win - WW'(1);
        unique case (grp)
            GRP_GLB: paddr = PAW'(idx);
            GRP_OUT: paddr = PAW'(8) + PAW'(win) * PAW'(16) + PAW'(idx);
            GRP_LOC: paddr = PAW'(16) + PAW'(win) * PAW'(16) + PAW'(idx);
            default: paddr = PAW'(8) + PAW'(prev_win) * PAW'(16) + PAW'(idx);
        endcase
    end
endmodule

// File: rtl/winreg_wctl.sv
module winreg_wctl #(
    parameter int NWIN = 8,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic          spill_done,
    input  logic          fill_done,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] res,
    output logic          ovf_trap,
    output logic          unf_trap
);
    localparam logic [WW-1:0] MAXRES = WW'(NWIN - 2);
    localparam logic [WW-1:0] LASTW  = WW'(NWIN - 1);

    typedef struct packed {
        logic [WW-1:0] cwp;
        logic [WW-1:0] res;
    } ctl_t;

    ctl_t st_d, st_q;
    logic save_ok_d, rest_ok_d, hs_solo_d;

    always_comb begin
        st_d      = st_q;
        save_ok_d = save_req && (st_q.res != MAXRES);
        rest_ok_d = restore_req && !save_req && (st_q.res != '0);
        ovf_trap  = save_req && (st_q.res == MAXRES);
        unf_trap  = restore_req && !save_req && (st_q.res == '0);
        hs_solo_d = !save_req && !restore_req && (spill_done ^ fill_done);
        if (save_ok_d) begin
            st_d.cwp = (st_q.cwp == LASTW) ? '0 : st_q.cwp + WW'(1);
            st_d.res = st_q.res + WW'(1);
        end else if (rest_ok_d) begin
            st_d.cwp = (st_q.cwp == '0) ? LASTW : st_q.cwp - WW'(1);
            st_d.res = st_q.res - WW'(1);
        end else if (hs_solo_d && spill_done && st_q.res != '0) begin
            st_d.res = st_q.res - WW'(1);
        end else if (hs_solo_d && fill_done && st_q.res != MAXRES) begin
            st_d.res = st_q.res + WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;
    assign res = st_q.res;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |=> ($stable(cwp) && $stable(res)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |=> ($stable(cwp) && $stable(res)));

    assert_res_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res <= MAXRES);

    assert_save_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !ovf_trap) |=> (res == $past(res) + WW'(1)));
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int WW   = $clog2(NWIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          rs1_addr,
    output logic [XLEN-1:0]     rs1_data,
    input  logic [4:0]          rs2_addr,
    output logic [XLEN-1:0]     rs2_data,
    input  logic                wr_en,
    input  logic [4:0]          wr_addr,
    input  logic [XLEN-1:0]     wr_data,
    input  logic                link_en,
    input  logic [XLEN-1:0]     link_pc,
    output logic [XLEN-1:0]     ret_addr,
    input  logic                save_req,
    input  logic                restore_req,
    output logic                ovf_trap,
    output logic                unf_trap,
    output logic [WW-1:0]       cur_win,
    output logic [WW-1:0]       resident,
    input  logic [WW-1:0]       hs_win,
    input  logic [3:0]          hs_off,
    input  logic                hs_we,
    input  logic [XLEN-1:0]     hs_wdata,
    output logic [XLEN-1:0]     hs_rdata,
    input  logic                spill_done,
    input  logic                fill_done
);
    localparam int NREG  = 8 + 16 * NWIN;
    localparam int PAW   = $clog2(NREG);
    localparam int NPORT = 5;
    localparam int P_RS1 = 0, P_RS2 = 1, P_WR = 2, P_RET = 3, P_LNK = 4;

    logic [LADDR_W-1:0] lad [NPORT];
    logic [PAW-1:0]     pad [NPORT];
    logic [PAW-1:0]     hs_p;
    logic               wr_live;
    logic [XLEN-1:0]    rf_d [NREG];
    logic [XLEN-1:0]    rf_q [NREG];

    winreg_wctl #(.NWIN(NWIN), .WW(WW)) u_wctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .spill_done  (spill_done),
        .fill_done   (fill_done),
        .cwp         (cur_win),
        .res         (resident),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    assign lad[P_RS1] = rs1_addr;
    assign lad[P_RS2] = rs2_addr;
    assign lad[P_WR]  = wr_addr;
    assign lad[P_RET] = 5'd31;
    assign lad[P_LNK] = 5'd15;

    for (genvar g = 0; g < NPORT; g++) begin : g_xlat
        winreg_xlat #(.NWIN(NWIN), .WW(WW), .PAW(PAW)) u_xlat (
            .win   (cur_win),
            .laddr (lad[g]),
            .paddr (pad[g])
        );
    end

    assign hs_p    = PAW'(8) + PAW'(hs_win) * PAW'(16) + PAW'(hs_off);
    assign wr_live = wr_en && (pad[P_WR] != '0);

    function automatic logic [XLEN-1:0] rd_port(input logic [PAW-1:0] p);
        if (p == '0)                        return '0;
        else if (link_en && p == pad[P_LNK]) return link_pc;
        else if (wr_live && p == pad[P_WR])  return wr_data;
        else                                return rf_q[p];
    endfunction

    always_comb begin
        rs1_data = rd_port(pad[P_RS1]);
        rs2_data = rd_port(pad[P_RS2]);
        ret_addr = rd_port(pad[P_RET]);
        hs_rdata = rf_q[hs_p];
    end

    always_comb begin
        rf_d = rf_q;
        if (hs_we)   rf_d[hs_p]       = hs_wdata;
        if (wr_live) rf_d[pad[P_WR]]  = wr_data;
        if (link_en) rf_d[pad[P_LNK]] = link_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == 5'd0) |-> (rs1_data == '0));
endmodule

// File: tb/winreg_file_tb.sv
module winreg_file_tb;
    localparam int NWIN   = 8;
    localparam int XLEN   = 32;
    localparam int WW     = $clog2(NWIN);
    localparam int PERIOD = 10;
    localparam int NVEC   = 8;

    localparam logic [36:0] VEC [NVEC] = '{
        {5'd0,  32'hDEAD0000}, {5'd1,  32'h11110001}, {5'd7,  32'h77770007},
        {5'd8,  32'h88880008}, {5'd15, 32'hFFFF000F}, {5'd16, 32'h16160010},
        {5'd23, 32'h23230017}, {5'd31, 32'h3131001F}
    };

    logic clk = 0, rst_n = 0;
    logic [4:0] rs1_addr, rs2_addr, wr_addr;
    logic [XLEN-1:0] rs1_data, rs2_data, wr_data, link_pc, ret_addr, hs_wdata, hs_rdata;
    logic wr_en, link_en, save_req, restore_req, ovf_trap, unf_trap;
    logic hs_we, spill_done, fill_done;
    logic [WW-1:0] cur_win, resident, hs_win;
    logic [3:0] hs_off;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    winreg_file #(.NWIN(NWIN), .XLEN(XLEN)) u_dut (.*);

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; link_en = 0; save_req = 0; restore_req = 0;
        hs_we = 0; spill_done = 0; fill_done = 0;
        wr_addr = 0; wr_data = 0; link_pc = 0; hs_win = 0; hs_off = 0; hs_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic wr(input logic [4:0] a, input logic [XLEN-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; tick();
    endtask

    task automatic rd(input logic [4:0] a, output logic [XLEN-1:0] d);
        rs1_addr = a; #1 d = rs1_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [XLEN-1:0] v;
        idle(); rs1_addr = 0; rs2_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R12 reset state
        chk("R12 cur_win", XLEN'(cur_win), 0);
        chk("R12 resident", XLEN'(resident), 0);
        chk("R12 traps", {30'd0, ovf_trap, unf_trap}, 0);
        rd(5'd20, v); chk("R12 reg clear", v, 0);

        // R1 R8 vector walk in window 0
        for (int i = 0; i < NVEC; i++) begin
            logic [4:0] a;
            logic [XLEN-1:0] d, e;
            a = VEC[i][36:32]; d = VEC[i][31:0];
            e = (a == 5'd0) ? '0 : d;
            wr(a, d);
            rs1_addr = a; rs2_addr = a; #1;
            chk((a == 0) ? "R8 zero reg" : "R1 port A", rs1_data, e);
            chk("R1 port B", rs2_data, e);
        end

        // R9 read during write
        wr_en = 1; wr_addr = 5'd17; wr_data = 32'h0000_1717; rs1_addr = 5'd17; #1;
        chk("R9 bypass", rs1_data, 32'h0000_1717);
        tick();

        // R2 R7 R9 save with write and link in same cycle
        wr(5'd16, 32'h0000_C0C0);
        save_req = 1; wr_en = 1; wr_addr = 5'd11; wr_data = 32'h0000_AAA1;
        link_en = 1; link_pc = 32'h0000_4000;
        tick();
        chk("R3 save cur_win", XLEN'(cur_win), 1);
        chk("R3 save resident", XLEN'(resident), 1);
        rd(5'd27, v); chk("R2 R9 out->in", v, 32'h0000_AAA1);
        chk("R7 ret_addr", ret_addr, 32'h0000_4000);
        wr(5'd16, 32'h0000_BEEF);
        restore_req = 1; tick();
        chk("R3 restore cur_win", XLEN'(cur_win), 0);
        rd(5'd16, v); chk("R4 caller local", v, 32'h0000_C0C0);
        rd(5'd15, v); chk("R7 link in out7", v, 32'h0000_4000);

        // R13 link wins over port write
        wr_en = 1; wr_addr = 5'd15; wr_data = 32'd1; link_en = 1; link_pc = 32'd2;
        tick();
        rd(5'd15, v); chk("R13 link priority", v, 32'd2);

        // R10 handler port
        hs_we = 1; hs_win = 0; hs_off = 4'd10; hs_wdata = 32'h55; tick();
        rd(5'd18, v); chk("R10 hs local write", v, 32'h55);
        hs_win = 0; hs_off = 4'd9; #1;
        chk("R10 hs read", hs_rdata, 32'h0000_1717);
        hs_we = 1; hs_win = 3'd7; hs_off = 4'd3; hs_wdata = 32'h77; tick();
        rd(5'd27, v); chk("R2 wrap in of win0", v, 32'h77);

        // R5 overflow
        for (int i = 0; i < NWIN - 2; i++) begin save_req = 1; tick(); end
        chk("R3 six saves", XLEN'(cur_win), 6);
        save_req = 1; #1;
        chk("R5 ovf_trap", XLEN'(ovf_trap), 1);
        tick();
        chk("R5 cur_win held", XLEN'(cur_win), 6);
        chk("R5 resident held", XLEN'(resident), 6);

        // R11 spill then retry, wrap
        spill_done = 1; tick();
        chk("R11 spill", XLEN'(resident), 5);
        save_req = 1; tick();
        spill_done = 1; tick();
        save_req = 1; tick();
        chk("R3 wrap cur_win", XLEN'(cur_win), 0);
        fill_done = 1; tick();
        chk("R11 fill at max ignored", XLEN'(resident), 6);

        // R6 underflow
        for (int i = 0; i < NWIN - 2; i++) begin restore_req = 1; tick(); end
        chk("R3 restores cur_win", XLEN'(cur_win), 2);
        restore_req = 1; #1;
        chk("R6 unf_trap", XLEN'(unf_trap), 1);
        tick();
        chk("R6 cur_win held", XLEN'(cur_win), 2);
        spill_done = 1; tick();
        chk("R11 spill at zero ignored", XLEN'(resident), 0);
        fill_done = 1; tick();
        chk("R11 fill", XLEN'(resident), 1);
        restore_req = 1; tick();
        chk("R11 retry restore", XLEN'(cur_win), 1);

        // R1 globals shared
        wr(5'd5, 32'h0505);
        save_req = 1; tick();
        rd(5'd5, v); chk("R1 global shared", v, 32'h0505);

        finish_run();
    end
endmodule